// File: doc/BRIEF.md
# MSI Capture Controller

This block is the root-port end of message-signalled interrupts. It watches a simple inbound write channel (strobe, 64-bit address, 32-bit data) and compares each address with a 64-bit target that software programs. When the address matches, the write data is taken as a vector number. If that vector is enabled, its status bit is set. Vectors are banked in groups of 32, so vector n is bit n%32 of group n/32. The number of groups is a parameter, up to 8.

Software reaches the target address and each group's enable, mask and status words through a small register port. Status bits are cleared by writing ones to them. A single interrupt line is raised while any status bit is set and not masked. Masking only hides a vector from the line: the vector still records into status. Write data that names a vector beyond the configured groups is dropped, and so is a write to any other address.

Top module: `msi_capture_ctrl`

## Requirements
- R1: After reset every register reads zero and irqOut is 0.
- R2: The target address low word is at register offset 0x820 and the high word at 0x824. Both read back what was written.
- R3: Group g has its enable word at 0x828+12g, its mask word at 0x82C+12g and its status word at 0x830+12g. Enable and mask read back what was written.
- R4: An inbound write whose 64-bit address equals {high word, low word} and whose data n is below NUM_GROUPS*32 sets status bit n%32 of group n/32, provided that enable bit is 1. The bit reads back set from the clock edge after the write.
- R5: An inbound write whose address differs from the target in any bit, high or low, changes no status bit.
- R6: An inbound write whose data is NUM_GROUPS*32 or more changes no status bit. The data is not truncated into range.
- R7: A vector whose enable bit is 0 does not set its status bit.
- R8: A register write to a status word clears each bit written as 1 and leaves each bit written as 0 unchanged. Software cannot set a status bit.
- R9: If a vector set and a software clear of the same status bit happen in the same cycle, the bit ends up set.
- R10: irqOut is 1 exactly when some group has a status bit set whose mask bit is 0. A masked vector still records into status.
- R11: A read of any offset that is not listed in R2 or R3, including the words of groups at or beyond NUM_GROUPS, returns zero. A write to such an offset has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| regWrEn | input | 1 | Register write strobe |
| regAddr | input | REG_ADDR_W | Register byte offset, used for both read and write |
| regWrData | input | 32 | Register write data |
| regRdData | output | 32 | Read data for regAddr, combinational from the registers |
| inWrValid | input | 1 | Inbound memory write strobe |
| inWrAddr | input | 64 | Inbound write address |
| inWrData | input | 32 | Inbound write data (vector number) |
| irqOut | output | 1 | Combined interrupt, OR of status and not mask over all groups |

## Verification
The bench builds the block with NUM_GROUPS set to 4 rather than the default 8. This puts the first out-of-range vector at 128, so both 128 and 256 can be checked as dropped without being folded into group 0. It also makes group 3 bit 31 (vector 127) the last valid vector. Finally, it turns the enable word of the absent group 4 at 0x858 into an undefined offset, so the bench can check that it reads zero both before and after a write.

// File: rtl/msi_cap_pkg.sv
package msi_cap_pkg;

  parameter int MSI_MAX_GROUPS   = 8;
  parameter int MSI_VEC_PER_GRP  = 32;
  parameter int MSI_GRP_IDX_W    = $clog2(MSI_MAX_GROUPS);
  parameter int MSI_BIT_IDX_W    = $clog2(MSI_VEC_PER_GRP);

  // Register offsets decoded by software; kept fixed.
  parameter int MSI_TGT_LO_OFF   = 'h820;
  parameter int MSI_TGT_HI_OFF   = 'h824;
  parameter int MSI_GRP_BASE_OFF = 'h828;
  parameter int MSI_GRP_STRIDE   = 12;
  parameter int MSI_MASK_DELTA   = 4;
  parameter int MSI_STAT_DELTA   = 8;

  typedef enum logic [2:0] {
    RK_NONE,
    RK_TGT_LO,
    RK_TGT_HI,
    RK_ENABLE,
    RK_MASK,
    RK_STATUS
  } reg_kind_e;

  // Strobes from control to datapath.
  typedef struct packed {
    logic                       regWr;
    reg_kind_e                  regKind;
    logic [MSI_GRP_IDX_W-1:0]   regGroup;
    logic                       capValid;
    logic [MSI_GRP_IDX_W-1:0]   capGroup;
    logic [MSI_BIT_IDX_W-1:0]   capBit;
  } msi_strobe_t;

endpackage

// File: rtl/msi_cap_ctrl.sv
module msi_cap_ctrl
  import msi_cap_pkg::*;
#(
  parameter int NUM_GROUPS = MSI_MAX_GROUPS,
  parameter int REG_ADDR_W = 12
) (
  input  logic                  regWrEn,
  input  logic [REG_ADDR_W-1:0] regAddr,
  input  logic                  inWrValid,
  input  logic [63:0]           inWrAddr,
  input  logic [31:0]           inWrData,
  input  logic [63:0]           targetAddr,
  output msi_strobe_t           strobe
);

  localparam int TOTAL_VEC = NUM_GROUPS * MSI_VEC_PER_GRP;

  logic addrHit;
  logic vecInRange;

  assign addrHit    = inWrValid && (inWrAddr == targetAddr);
  assign vecInRange = (inWrData < 32'(TOTAL_VEC));

  always_comb begin
    strobe          = '0;
    strobe.regKind  = RK_NONE;
    strobe.regWr    = regWrEn;

    if (regAddr == REG_ADDR_W'(MSI_TGT_LO_OFF)) strobe.regKind = RK_TGT_LO;
    if (regAddr == REG_ADDR_W'(MSI_TGT_HI_OFF)) strobe.regKind = RK_TGT_HI;

    for (int g = 0; g < NUM_GROUPS; g++) begin
      if (regAddr == REG_ADDR_W'(MSI_GRP_BASE_OFF + g * MSI_GRP_STRIDE)) begin
        strobe.regKind  = RK_ENABLE;
        strobe.regGroup = MSI_GRP_IDX_W'(g);
      end
      if (regAddr == REG_ADDR_W'(MSI_GRP_BASE_OFF + g * MSI_GRP_STRIDE + MSI_MASK_DELTA)) begin
        strobe.regKind  = RK_MASK;
        strobe.regGroup = MSI_GRP_IDX_W'(g);
      end
      if (regAddr == REG_ADDR_W'(MSI_GRP_BASE_OFF + g * MSI_GRP_STRIDE + MSI_STAT_DELTA)) begin
        strobe.regKind  = RK_STATUS;
        strobe.regGroup = MSI_GRP_IDX_W'(g);
      end
    end

    strobe.capValid = addrHit && vecInRange;
    strobe.capGroup = inWrData[MSI_BIT_IDX_W +: MSI_GRP_IDX_W];
    strobe.capBit   = inWrData[MSI_BIT_IDX_W-1:0];
  end

endmodule

// File: rtl/msi_cap_datapath.sv
module msi_cap_datapath
  import msi_cap_pkg::*;
#(
  parameter int NUM_GROUPS = MSI_MAX_GROUPS,
  localparam int TOTAL_VEC = NUM_GROUPS * MSI_VEC_PER_GRP
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  msi_strobe_t          strobe,
  input  logic [31:0]          regWrData,
  output logic [31:0]          regRdData,
  output logic [63:0]          targetAddr,
  output logic [TOTAL_VEC-1:0] enableFlat,
  output logic [TOTAL_VEC-1:0] maskFlat,
  output logic [TOTAL_VEC-1:0] statusFlat,
  output logic                 irqOut
);

  logic [31:0] tgtLo;
  logic [31:0] tgtHi;
  logic [MSI_VEC_PER_GRP-1:0] enableR [NUM_GROUPS];
  logic [MSI_VEC_PER_GRP-1:0] maskR   [NUM_GROUPS];
  logic [MSI_VEC_PER_GRP-1:0] statusR [NUM_GROUPS];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      tgtLo <= '0;
      tgtHi <= '0;
    end else if (strobe.regWr) begin
      if (strobe.regKind == RK_TGT_LO) tgtLo <= regWrData;
      if (strobe.regKind == RK_TGT_HI) tgtHi <= regWrData;
    end
  end

  assign targetAddr = {tgtHi, tgtLo};

  for (genvar g = 0; g < NUM_GROUPS; g++) begin : gen_group
    logic selGrp;
    logic capGrp;
    logic [MSI_VEC_PER_GRP-1:0] setVec;
    logic [MSI_VEC_PER_GRP-1:0] clrVec;

    assign selGrp = strobe.regWr && (strobe.regGroup == MSI_GRP_IDX_W'(g));
    assign capGrp = strobe.capValid && (strobe.capGroup == MSI_GRP_IDX_W'(g));
    assign setVec = capGrp ? ((MSI_VEC_PER_GRP'(1) << strobe.capBit) & enableR[g]) : '0;
    assign clrVec = (selGrp && strobe.regKind == RK_STATUS) ? regWrData : '0;

    always_ff @(posedge clk) begin
      if (!rstN) begin
        enableR[g] <= '0;
        maskR[g]   <= '0;
        statusR[g] <= '0;
      end else begin
        if (selGrp && strobe.regKind == RK_ENABLE) enableR[g] <= regWrData;
        if (selGrp && strobe.regKind == RK_MASK)   maskR[g]   <= regWrData;
        // A new event outranks a clear of the same bit.
        statusR[g] <= (statusR[g] & ~clrVec) | setVec;
      end
    end

    assign enableFlat[g*MSI_VEC_PER_GRP +: MSI_VEC_PER_GRP] = enableR[g];
    assign maskFlat[g*MSI_VEC_PER_GRP +: MSI_VEC_PER_GRP]   = maskR[g];
    assign statusFlat[g*MSI_VEC_PER_GRP +: MSI_VEC_PER_GRP] = statusR[g];
  end

  always_comb begin
    regRdData = '0;
    case (strobe.regKind)
      RK_TGT_LO: regRdData = tgtLo;
      RK_TGT_HI: regRdData = tgtHi;
      default: begin
        for (int g = 0; g < NUM_GROUPS; g++) begin
          if (strobe.regGroup == MSI_GRP_IDX_W'(g)) begin
            if (strobe.regKind == RK_ENABLE) regRdData = enableR[g];
            if (strobe.regKind == RK_MASK)   regRdData = maskR[g];
            if (strobe.regKind == RK_STATUS) regRdData = statusR[g];
          end
        end
      end
    endcase
  end

  assign irqOut = |(statusFlat & ~maskFlat);

endmodule

// File: rtl/msi_capture_ctrl.sv
module msi_capture_ctrl
  import msi_cap_pkg::*;
#(
  parameter int NUM_GROUPS = MSI_MAX_GROUPS,
  parameter int REG_ADDR_W = 12,
  localparam int TOTAL_VEC = NUM_GROUPS * MSI_VEC_PER_GRP
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  regWrEn,
  input  logic [REG_ADDR_W-1:0] regAddr,
  input  logic [31:0]           regWrData,
  output logic [31:0]           regRdData,
  input  logic                  inWrValid,
  input  logic [63:0]           inWrAddr,
  input  logic [31:0]           inWrData,
  output logic                  irqOut
);

  msi_strobe_t          strobe;
  logic [63:0]          targetAddr;
  logic [TOTAL_VEC-1:0] enableFlat;
  logic [TOTAL_VEC-1:0] maskFlat;
  logic [TOTAL_VEC-1:0] statusFlat;

  msi_cap_ctrl #(
    .NUM_GROUPS (NUM_GROUPS),
    .REG_ADDR_W (REG_ADDR_W)
  ) u_ctrl (
    .regWrEn    (regWrEn),
    .regAddr    (regAddr),
    .inWrValid  (inWrValid),
    .inWrAddr   (inWrAddr),
    .inWrData   (inWrData),
    .targetAddr (targetAddr),
    .strobe     (strobe)
  );

  msi_cap_datapath #(
    .NUM_GROUPS (NUM_GROUPS)
  ) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .strobe     (strobe),
    .regWrData  (regWrData),
    .regRdData  (regRdData),
    .targetAddr (targetAddr),
    .enableFlat (enableFlat),
    .maskFlat   (maskFlat),
    .statusFlat (statusFlat),
    .irqOut     (irqOut)
  );

endmodule

// File: rtl/msi_cap_checker.sv
module msi_cap_checker
  import msi_cap_pkg::*;
#(
  parameter int NUM_GROUPS = MSI_MAX_GROUPS,
  localparam int TOTAL_VEC = NUM_GROUPS * MSI_VEC_PER_GRP,
  localparam int VIDX_W    = $clog2(TOTAL_VEC)
) (
  input logic                 clk,
  input logic                 rstN,
  input logic                 inWrValid,
  input logic [63:0]          inWrAddr,
  input logic [31:0]          inWrData,
  input logic [63:0]          targetAddr,
  input logic [TOTAL_VEC-1:0] enableFlat,
  input logic [TOTAL_VEC-1:0] statusFlat,
  input logic                 irqOut
);

  logic hitNow;
  logic inRange;
  assign hitNow  = inWrValid && (inWrAddr == targetAddr);
  assign inRange = (inWrData < 32'(TOTAL_VEC));

  // R1: reset leaves status empty and the line low.
  p_reset_clear_r1: assert property (@(posedge clk)
    !rstN |=> (statusFlat == '0 && !irqOut));

  // R4, and R9 since a concurrent clear must not stop the set.
  p_hit_sets_r4: assert property (@(posedge clk) disable iff (!rstN)
    (hitNow && inRange && enableFlat[inWrData[VIDX_W-1:0]])
      |=> statusFlat[$past(inWrData[VIDX_W-1:0])]);

  // R5: nothing rises without an address match.
  p_miss_no_set_r5: assert property (@(posedge clk) disable iff (!rstN)
    !hitNow |=> ((statusFlat & ~$past(statusFlat)) == '0));

  // R6: out-of-range vector numbers are dropped.
  p_out_of_range_r6: assert property (@(posedge clk) disable iff (!rstN)
    (inWrValid && !inRange) |=> ((statusFlat & ~$past(statusFlat)) == '0));

  // R7: a disabled vector never records.
  p_disabled_r7: assert property (@(posedge clk) disable iff (!rstN)
    (hitNow && inRange && !enableFlat[inWrData[VIDX_W-1:0]])
      |=> ((statusFlat & ~$past(statusFlat)) == '0));

endmodule

bind msi_capture_ctrl msi_cap_checker #(
  .NUM_GROUPS (NUM_GROUPS)
) u_msiChk (
  .clk        (clk),
  .rstN       (rstN),
  .inWrValid  (inWrValid),
  .inWrAddr   (inWrAddr),
  .inWrData   (inWrData),
  .targetAddr (targetAddr),
  .enableFlat (enableFlat),
  .statusFlat (statusFlat),
  .irqOut     (irqOut)
);

// File: tb/msi_capture_ctrl_bench.sv
module msi_capture_ctrl_bench;

  localparam int NG = 4;
  localparam logic [63:0] TGT = 64'h0000_0001_FEE0_1000;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        regWrEn = 1'b0;
  logic [11:0] regAddr = '0;
  logic [31:0] regWrData = '0;
  logic [31:0] regRdData;
  logic        inWrValid = 1'b0;
  logic [63:0] inWrAddr = '0;
  logic [31:0] inWrData = '0;
  logic        irqOut;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  typedef struct {
    logic [11:0] addr;
    logic [31:0] data;
    logic        irq;
    string       tag;
  } exp_item_t;

  exp_item_t expQ[$];

  always #10 clk = ~clk;

  msi_capture_ctrl #(.NUM_GROUPS(NG)) u_msi_capture_ctrl (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regAddr(regAddr),
    .regWrData(regWrData), .regRdData(regRdData), .inWrValid(inWrValid),
    .inWrAddr(inWrAddr), .inWrData(inWrData), .irqOut(irqOut)
  );

  // Monitor: one queued expectation is compared per falling edge.
  always @(negedge clk) begin
    if (expQ.size() > 0) begin
      exp_item_t it;
      it = expQ.pop_front();
      checks++;
      if (regRdData !== it.data) begin
        errors++;
        $display("FAIL %s: read 0x%03h got 0x%08h expected 0x%08h", it.tag, it.addr, regRdData, it.data);
      end
      checks++;
      if (irqOut !== it.irq) begin
        errors++;
        $display("FAIL %s: irqOut at 0x%03h got %0b expected %0b", it.tag, it.addr, irqOut, it.irq);
      end
    end
  end

  task automatic expectRead(input logic [11:0] a, input logic [31:0] d, input logic irq, input string tag);
    exp_item_t it;
    @(negedge clk); #1;
    regAddr = a;
    it.addr = a; it.data = d; it.irq = irq; it.tag = tag;
    expQ.push_back(it);
  endtask

  task automatic regWrite(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk); #1;
    regAddr = a; regWrData = d; regWrEn = 1'b1;
    @(posedge clk); #1;
    regWrEn = 1'b0;
  endtask

  task automatic msiSend(input logic [63:0] a, input logic [31:0] d);
    @(negedge clk); #1;
    inWrAddr = a; inWrData = d; inWrValid = 1'b1;
    @(posedge clk); #1;
    inWrValid = 1'b0;
  endtask

  task automatic sendAndClear(input logic [31:0] vec, input logic [11:0] a, input logic [31:0] d);
    @(negedge clk); #1;
    inWrAddr = TGT; inWrData = vec; inWrValid = 1'b1;
    regAddr = a; regWrData = d; regWrEn = 1'b1;
    @(posedge clk); #1;
    inWrValid = 1'b0; regWrEn = 1'b0;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;

    // R1 reset state
    expectRead(12'h820, 32'h0, 1'b0, "R1");
    expectRead(12'h824, 32'h0, 1'b0, "R1");
    expectRead(12'h830, 32'h0, 1'b0, "R1");

    // R2 target address
    regWrite(12'h820, TGT[31:0]);
    regWrite(12'h824, TGT[63:32]);
    expectRead(12'h820, 32'hFEE0_1000, 1'b0, "R2");
    expectRead(12'h824, 32'h0000_0001, 1'b0, "R2");

    // R3 group layout: g0 enable 0x828, g1 enable 0x834, g3 enable 0x84C
    regWrite(12'h828, 32'h0000_00F1);
    regWrite(12'h834, 32'h8000_0001);
    regWrite(12'h84C, 32'h8000_0100);
    regWrite(12'h82C, 32'h0000_0020);
    regWrite(12'h844, 32'h1234_5678);
    expectRead(12'h834, 32'h8000_0001, 1'b0, "R3");
    expectRead(12'h82C, 32'h0000_0020, 1'b0, "R3");
    expectRead(12'h844, 32'h1234_5678, 1'b0, "R3");

    // R4/R10: masked vector 5 latches but keeps the line low
    msiSend(TGT, 32'd5);
    expectRead(12'h830, 32'h0000_0020, 1'b0, "R10");
    msiSend(TGT, 32'd4);
    expectRead(12'h830, 32'h0000_0030, 1'b1, "R4");
    msiSend(TGT, 32'd63);
    expectRead(12'h83C, 32'h8000_0000, 1'b1, "R4");

    // R7 disabled vector 3
    msiSend(TGT, 32'd3);
    expectRead(12'h830, 32'h0000_0030, 1'b1, "R7");

    // R5 mismatching address, low or high word (vector 0 is enabled)
    msiSend(TGT + 64'd4, 32'd0);
    msiSend({32'h0, TGT[31:0]}, 32'd0);
    expectRead(12'h830, 32'h0000_0030, 1'b1, "R5");

    // R6 out of range vectors 128 and 256
    msiSend(TGT, 32'd128);
    msiSend(TGT, 32'd256);
    expectRead(12'h830, 32'h0000_0030, 1'b1, "R6");
    expectRead(12'h848, 32'h0, 1'b1, "R6");
    expectRead(12'h854, 32'h0, 1'b1, "R6");

    // R4 last valid vector 127 -> group 3 bit 31
    msiSend(TGT, 32'd127);
    expectRead(12'h854, 32'h8000_0000, 1'b1, "R4");

    // R8 write-one-to-clear
    regWrite(12'h830, 32'h0000_0010);
    expectRead(12'h830, 32'h0000_0020, 1'b1, "R8");
    regWrite(12'h830, 32'h0000_0000);
    expectRead(12'h830, 32'h0000_0020, 1'b1, "R8");
    regWrite(12'h83C, 32'hFFFF_FFFF);
    regWrite(12'h854, 32'h8000_0000);
    expectRead(12'h83C, 32'h0, 1'b0, "R8");
    expectRead(12'h854, 32'h0, 1'b0, "R10");

    // R10 unmask exposes the latched vector
    regWrite(12'h82C, 32'h0);
    expectRead(12'h82C, 32'h0, 1'b1, "R10");
    regWrite(12'h830, 32'h0000_0020);
    expectRead(12'h830, 32'h0, 1'b0, "R10");

    // R9 set wins over same-cycle clear
    sendAndClear(32'd6, 12'h830, 32'h0000_0040);
    expectRead(12'h830, 32'h0000_0040, 1'b1, "R9");

    // R7 enable cleared turns vector 7 off
    regWrite(12'h828, 32'h0);
    msiSend(TGT, 32'd7);
    expectRead(12'h830, 32'h0000_0040, 1'b1, "R7");

    // R11 undefined offsets
    expectRead(12'h858, 32'h0, 1'b1, "R11");
    regWrite(12'h858, 32'h0000_FFFF);
    expectRead(12'h858, 32'h0, 1'b1, "R11");
    expectRead(12'h900, 32'h0, 1'b1, "R11");
    expectRead(12'h81C, 32'h0, 1'b1, "R11");

    @(negedge clk);
    @(negedge clk);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: run did not complete, got hung expected done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule